// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Ready Handshake

This block takes in bytes on a three-wire synchronous serial link: a serial clock and a data line, both driven by the remote sender, plus an active-low ready line that the block drives back. The sender may run the serial clock only after it sees the ready line low. Both incoming wires pass through a synchronizer and are sampled in the system clock domain, so the serial clock must run several times slower than the system clock.

Software uses a four-address register port. To arm the receiver, it sets the receive and transmit enables in the control register and writes a dummy byte to the transmit address. These can happen in any order. The block then drops the ready line. Each selected edge of the serial clock shifts one data bit into a shift register. The default edge is rising, and a control bit selects falling instead. After `DATA_W` bits the shifted word is copied into the receive buffer. At that point the complete flag and the interrupt request are set and the ready line rises again. The next byte needs a new dummy write.

The control state machine has three states. In `ST_IDLE` the ready line is high, edges are ignored and partial data is cleared. In `ST_READY` the block is armed and waits for the first bit. In `ST_SHIFT` bits are arriving. The transitions are:
- arm (`ST_IDLE`→`ST_READY`), when the dummy write is pending and both enables are set;
- first bit (`ST_READY`→`ST_SHIFT`);
- last bit (`ST_SHIFT`→`ST_IDLE`), which loads the buffer;
- abort (`ST_READY`/`ST_SHIFT`→`ST_IDLE`), when either enable is cleared.

Top module: `csync_rx`

## Requirements
- R1: After reset the ready output is high, the interrupt output is low, and the control (address 1), receive buffer (address 2) and status (address 3) registers all read 0.
- R2: The ready output goes low only when a dummy write to address 0 is pending and control bits 0 (receive enable) and 1 (transmit enable) are both set, whatever order these happen in. Any two of the three alone leave it high.
- R3: With control bit 2 clear, data is sampled on rising serial clock edges. With control bit 2 set, data is sampled on falling edges only.
- R4: With control bit 4 clear (LSB first), each sampled bit enters the top of the shift register and the register shifts right, so the first bit received ends up in buffer bit 0.
- R5: With control bit 4 set (MSB first), the first bit received ends up in buffer bit `DATA_W-1`.
- R6: With control bit 3 set, every received bit is inverted before it is stored.
- R7: After the `DATA_W`-th sampled bit, the buffer holds the word, status bit 0 (complete) and status bit 1 / `irq_o` (interrupt) are set, and the ready output returns high.
- R8: Reading address 2 clears the complete flag and leaves the interrupt request set.
- R9: The interrupt request clears only when control bit 5 is written as 0. Writing 1 there leaves it unchanged. It reads back at control bit 5.
- R10: Once a word is received, further serial clock edges without a new dummy write change neither the buffer nor the flags, and the ready output stays high.
- R11: Clearing either enable while armed or mid-word returns the ready output high and discards the partial bits and the pending dummy write. Re-enabling alone does not re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the sender |
| rxd_i | input | 1 | Serial data from the sender |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address (0 transmit, 1 control, 2 receive buffer, 3 status) |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data, combinational from the address |
| rts_no | output | 1 | Active-low ready-to-receive |
| irq_o | output | 1 | Receive interrupt request |

## Verification
Directed words with marked bit patterns are sent first: 0xA5, a single leading 1, and all zeros with inversion. These separate LSB-first from MSB-first placement and show that inversion is applied. In the falling-edge case the data line holds the wrong value across the non-sampling edge, so sampling on the wrong edge shows up as an inverted word. Seeded random words with random edge, order and inversion settings are checked against a bench model of the bit placement. Directed sequences cover the arming orders, an abort after three bits followed by a clean word, and stray edges after completion.

// File: rtl/csrx_pkg.sv
package csrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    localparam logic [1:0] ADDR_TXD  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_RXB  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CTL_RXEN = 0;
    localparam int CTL_TXEN = 1;
    localparam int CTL_FALL = 2;
    localparam int CTL_INV  = 3;
    localparam int CTL_MSB  = 4;
    localparam int CTL_IRQ  = 5;

    localparam int STAT_DONE = 0;
    localparam int STAT_IRQ  = 1;

endpackage

// File: rtl/csrx_sync.sv
module csrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic rxd_i,
    input  logic fall_sel_i,
    output logic edge_o,
    output logic bit_o
);

    logic [STAGES-1:0] ck_pipe;
    logic [STAGES-1:0] dt_pipe;
    logic              ck_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) begin
                        ck_pipe[0] <= 1'b0;
                        dt_pipe[0] <= 1'b0;
                    end else begin
                        ck_pipe[0] <= sclk_i;
                        dt_pipe[0] <= rxd_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) begin
                        ck_pipe[g] <= 1'b0;
                        dt_pipe[g] <= 1'b0;
                    end else begin
                        ck_pipe[g] <= ck_pipe[g-1];
                        dt_pipe[g] <= dt_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ck_prev <= 1'b0;
        else         ck_prev <= ck_pipe[STAGES-1];
    end

    always_comb begin
        if (fall_sel_i) edge_o = ck_prev & ~ck_pipe[STAGES-1];
        else            edge_o = ~ck_prev & ck_pipe[STAGES-1];
        bit_o = dt_pipe[STAGES-1];
    end

    // R3
    edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> (!edge_o || !$stable(fall_sel_i)));

endmodule

// File: rtl/csrx_shift.sv
module csrx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic              bit_i,
    input  logic              msb_first_i,
    input  logic              invert_i,
    output logic [DATA_W-1:0] next_o
);

    logic [DATA_W-1:0] sr_q;
    logic              bit_v;

    always_comb begin
        bit_v = bit_i ^ invert_i;
        if (msb_first_i) next_o = {sr_q[DATA_W-2:0], bit_v};
        else             next_o = {bit_v, sr_q[DATA_W-1:1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (clr_i)   sr_q <= '0;
        else if (take_i)  sr_q <= next_o;
    end

    // R11
    clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (sr_q == '0));

endmodule

// File: rtl/csrx_ctrl.sv
module csrx_ctrl
    import csrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_req_i,
    input  logic en_ok_i,
    input  logic sample_i,
    output logic take_o,
    output logic done_o,
    output logic abort_o,
    output logic clr_o,
    output logic rts_no
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_req_i) state_d = ST_READY;
            end
            ST_READY: begin
                if (!en_ok_i)      state_d = ST_IDLE;
                else if (sample_i) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!en_ok_i)                          state_d = ST_IDLE;
                else if (sample_i && (cnt_q == LAST))  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        take_o  = 1'b0;
        done_o  = 1'b0;
        abort_o = 1'b0;
        clr_o   = 1'b0;
        rts_no  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                clr_o = 1'b1;
            end
            ST_READY: begin
                rts_no  = 1'b0;
                abort_o = !en_ok_i;
                take_o  = en_ok_i && sample_i;
            end
            ST_SHIFT: begin
                rts_no  = 1'b0;
                abort_o = !en_ok_i;
                take_o  = en_ok_i && sample_i;
                done_o  = en_ok_i && sample_i && (cnt_q == LAST);
            end
            default: clr_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_q <= '0;
        else if (clr_o || abort_o || done_o)  cnt_q <= '0;
        else if (take_o)                      cnt_q <= cnt_q + 1'b1;
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

    // R2
    rts_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rts_no) |-> $past(arm_req_i));

    // R11
    abort_rts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rts_no && !en_ok_i) |=> rts_no);

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rts_no && !arm_req_i) |=> rts_no);

endmodule

// File: rtl/csync_rx.sv
module csync_rx
    import csrx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              rxd_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rts_no,
    output logic              irq_o
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rxbuf_q;
    logic              dummy_q;
    logic              cmpl_q;
    logic              irq_q;

    logic edge_s, bit_s;
    logic take_s, done_s, abort_s, clr_s;
    logic en_ok, arm_req;
    logic wr_txd, wr_ctrl, rd_rxb;
    logic [DATA_W-1:0] word_s;

    assign en_ok   = ctrl_q[CTL_RXEN] & ctrl_q[CTL_TXEN];
    assign arm_req = dummy_q & en_ok;
    assign wr_txd  = bus_wr_i && (bus_addr_i == ADDR_TXD);
    assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign rd_rxb  = bus_rd_i && (bus_addr_i == ADDR_RXB);

    csrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sclk_i     (sclk_i),
        .rxd_i      (rxd_i),
        .fall_sel_i (ctrl_q[CTL_FALL]),
        .edge_o     (edge_s),
        .bit_o      (bit_s)
    );

    csrx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_req_i (arm_req),
        .en_ok_i   (en_ok),
        .sample_i  (edge_s),
        .take_o    (take_s),
        .done_o    (done_s),
        .abort_o   (abort_s),
        .clr_o     (clr_s),
        .rts_no    (rts_no)
    );

    csrx_shift #(.DATA_W(DATA_W)) shift_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (clr_s),
        .take_i      (take_s),
        .bit_i       (bit_s),
        .msb_first_i (ctrl_q[CTL_MSB]),
        .invert_i    (ctrl_q[CTL_INV]),
        .next_o      (word_s)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q          <= bus_wdata_i;
            ctrl_q[CTL_IRQ] <= 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  dummy_q <= 1'b0;
        else if (wr_txd)              dummy_q <= 1'b1;
        else if (done_s || abort_s)   dummy_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     rxbuf_q <= '0;
        else if (done_s) rxbuf_q <= word_s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cmpl_q <= 1'b0;
        else if (done_s) cmpl_q <= 1'b1;
        else if (rd_rxb) cmpl_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                irq_q <= 1'b0;
        else if (done_s)                            irq_q <= 1'b1;
        else if (wr_ctrl && !bus_wdata_i[CTL_IRQ])  irq_q <= 1'b0;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            ADDR_TXD:  bus_rdata_o = '0;
            ADDR_CTRL: begin
                bus_rdata_o          = ctrl_q;
                bus_rdata_o[CTL_IRQ] = irq_q;
            end
            ADDR_RXB:  bus_rdata_o = rxbuf_q;
            ADDR_STAT: begin
                bus_rdata_o[STAT_DONE] = cmpl_q;
                bus_rdata_o[STAT_IRQ]  = irq_q;
            end
            default:   bus_rdata_o = '0;
        endcase
        irq_o = irq_q;
    end

    // R7
    done_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_s |=> (cmpl_q && irq_q && rts_no));

    // R8
    rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_rxb && !done_s) |=> !cmpl_q);

    // R9
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_q && !(wr_ctrl && !bus_wdata_i[CTL_IRQ])) |=> irq_q);

    // R10
    buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_s |=> $stable(rxbuf_q));

endmodule

// File: tb/csync_rx_tb_top.sv
`timescale 1ns/1ps
module csync_rx_tb_top;

    localparam int W    = 8;
    localparam int HOLD = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b1;
    logic         rxd = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         rts_n;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    csync_rx #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sclk_i      (sclk),
        .rxd_i       (rxd),
        .bus_wr_i    (wr_en),
        .bus_rd_i    (rd_en),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .rts_no      (rts_n),
        .irq_o       (irq)
    );

    function automatic logic [W-1:0] mk_ctrl(input bit rx, input bit tx, input bit fall,
                                             input bit inv, input bit msb, input bit irqb);
        logic [W-1:0] c;
        c = '0;
        c[0] = rx; c[1] = tx; c[2] = fall; c[3] = inv; c[4] = msb; c[5] = irqb;
        return c;
    endfunction

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] seq, input bit msb, input bit inv);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (msb) r[W-1-i] = seq[i];
            else     r[i]     = seq[i];
        end
        return r ^ {W{inv}};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle_level(input bit fall);
        sclk = fall ? 1'b0 : 1'b1;
        wait_cyc(HOLD);
    endtask

    // seq[i] is the i-th bit on the wire; the wrong value is held across the
    // non-sampling edge and the right one only just before the sampling edge.
    task automatic send_bits(input logic [W-1:0] seq, input int n, input bit fall);
        for (int i = 0; i < n; i++) begin
            rxd  = ~seq[i];
            sclk = fall ? 1'b1 : 1'b0;
            wait_cyc(HOLD / 2);
            rxd  = seq[i];
            wait_cyc(HOLD / 2);
            sclk = fall ? 1'b0 : 1'b1;
            wait_cyc(HOLD);
        end
        wait_cyc(HOLD);
    endtask

    logic [W-1:0] rv;

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (R1..) actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);

        // R1 reset state
        check("R1 rts_n", {7'd0, rts_n}, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        bus_rd(2'd1, rv); check("R1 ctrl", rv, 8'h00);
        bus_rd(2'd3, rv); check("R1 status", rv, 8'h00);
        bus_rd(2'd2, rv); check("R1 rxbuf", rv, 8'h00);

        // R2 enables without dummy write stay idle
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 0, 0, 0));
        wait_cyc(4);
        check("R2 no dummy", {7'd0, rts_n}, 8'h01);
        bus_wr(2'd0, 8'h5A);
        wait_cyc(2);
        check("R2 armed", {7'd0, rts_n}, 8'h00);

        // R4 LSB first, default rising edge
        send_bits(8'hA5, W, 0);
        check("R7 rts back high", {7'd0, rts_n}, 8'h01);
        check("R7 irq pin", {7'd0, irq}, 8'h01);
        bus_rd(2'd3, rv); check("R7 status", rv, 8'h03);
        bus_rd(2'd2, rv); check("R4 lsb word", rv, exp_word(8'hA5, 0, 0));
        bus_rd(2'd3, rv); check("R8 complete cleared", rv, 8'h02);

        // R10 stray edges after completion
        send_bits(8'h3C, W, 0);
        bus_rd(2'd2, rv); check("R10 buffer held", rv, 8'hA5);
        bus_rd(2'd3, rv); check("R10 flags held", rv, 8'h02);
        check("R10 rts high", {7'd0, rts_n}, 8'h01);

        // R9 irq clear semantics
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 0, 0, 1));
        check("R9 write one keeps", {7'd0, irq}, 8'h01);
        bus_rd(2'd1, rv); check("R9 ctrl readback", rv, mk_ctrl(1, 1, 0, 0, 0, 1));
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 0, 0, 0));
        check("R9 write zero clears", {7'd0, irq}, 8'h00);

        // R2 other order: dummy first, then enables one at a time
        bus_wr(2'd1, mk_ctrl(0, 0, 0, 0, 0, 0));
        bus_wr(2'd0, 8'h00);
        wait_cyc(2);
        check("R2 dummy only", {7'd0, rts_n}, 8'h01);
        bus_wr(2'd1, mk_ctrl(1, 0, 0, 0, 0, 0));
        wait_cyc(2);
        check("R2 one enable", {7'd0, rts_n}, 8'h01);
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 0, 0, 0));
        wait_cyc(2);
        check("R2 all three", {7'd0, rts_n}, 8'h00);

        // R11 abort mid-word
        send_bits(8'hFF, 3, 0);
        bus_wr(2'd1, mk_ctrl(0, 1, 0, 0, 0, 0));
        wait_cyc(2);
        check("R11 abort rts", {7'd0, rts_n}, 8'h01);
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 0, 0, 0));
        wait_cyc(2);
        check("R11 no rearm", {7'd0, rts_n}, 8'h01);
        bus_wr(2'd0, 8'h00);
        send_bits(8'h81, W, 0);
        bus_rd(2'd2, rv); check("R11 partial discarded", rv, 8'h81);

        // R5 MSB first
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 0, 1, 0));
        bus_wr(2'd0, 8'h00);
        send_bits(8'h01, W, 0);
        bus_rd(2'd2, rv); check("R5 msb word", rv, 8'h80);

        // R6 inversion
        bus_wr(2'd1, mk_ctrl(1, 1, 0, 1, 0, 0));
        bus_wr(2'd0, 8'h00);
        send_bits(8'h00, W, 0);
        bus_rd(2'd2, rv); check("R6 inverted", rv, 8'hFF);

        // R3 falling edge
        bus_wr(2'd1, mk_ctrl(1, 1, 1, 0, 0, 0));
        idle_level(1);
        bus_wr(2'd0, 8'h00);
        send_bits(8'h6D, W, 1);
        bus_rd(2'd2, rv); check("R3 falling edge", rv, 8'h6D);

        // random mix (R3 R4 R5 R6 R7)
        for (int t = 0; t < 24; t++) begin
            bit f, inv, msb;
            logic [W-1:0] seq;
            f   = $urandom() % 2;
            inv = $urandom() % 2;
            msb = $urandom() % 2;
            seq = W'($urandom());
            bus_wr(2'd1, mk_ctrl(1, 1, f, inv, msb, 0));
            idle_level(f);
            bus_wr(2'd0, 8'h00);
            wait_cyc(2);
            check("R2 random arm", {7'd0, rts_n}, 8'h00);
            send_bits(seq, W, f);
            check("R7 random irq", {7'd0, irq}, 8'h01);
            bus_rd(2'd2, rv);
            check("R3/R4/R5/R6 random word", rv, exp_word(seq, msb, inv));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule